// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block gathers a group of condition signals and makes each of them visible to a host in three forms. The first is a real-time view of the current level. The second is an onset latch that records every low-to-high change. The third is an ending latch that records every high-to-low change. The conditions arrive as synchronous level inputs. The block finds each change by comparing an input with its value from the previous clock.

The host uses a small synchronous port. A read captures the addressed word into a holding register, and the value appears on `rdata` one clock later. The host clears a latch by writing a 1 to its position. This works even if the condition is still active, and the latch sets again only on a new change. Each latch has a mask bit, where 1 means enabled. The active-low interrupt output is low while any enabled latch is set.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: A read of word address 0 returns, one clock after the read strobe, the level of `cond_i` sampled at the clock edge that took the strobe.
- R2: Reads of any address never change a latch bit.
- R3: `rdata` keeps its value in every cycle without a read strobe, even while `cond_i` changes.
- R4: A 0-to-1 change of `cond_i[i]` sets bit i of the onset latch word (address 1) at that clock edge.
- R5: A 1-to-0 change of `cond_i[i]` sets bit i of the ending latch word (address 2) at that clock edge.
- R6: Writing `wdata` to address 1 or 2 clears exactly the bits where `wdata` is 1 and leaves the others unchanged. This holds while the condition is still active, and a cleared bit stays 0 until a new change occurs.
- R7: If a clearing write and a new change for the same bit fall on the same clock edge, the bit ends up set.
- R8: Address 3 holds the onset mask and address 4 holds the ending mask. Both are read/write, and a 1 means enabled. `irq_n` is 0 exactly when some latch bit and its mask bit are both 1.
- R9: After reset, all latches and masks read 0, `irq_n` is 1 and `rdata` is 0.
- R10: Writes to address 0 and to addresses 5 to 7 change nothing, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | N | Synchronous condition levels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wdata | input | N | Write data |
| rdata | output | N | Read data, held between reads |
| irq_n | output | 1 | Interrupt, active low |

## Verification
All 256 condition patterns are driven one after another through real-time reads. This separates per-bit level capture from onset and ending latching, because a pattern sweep produces rises and falls on every bit in many different combinations. All 256 onset mask values are applied over a fixed latch pattern. This shows whether the interrupt combines exactly the enabled bits. Directed sequences then test clearing while a condition persists, a clear that collides with a new edge, and writes to read-only or unmapped addresses. Each of these tells a correct write-1-to-clear apart from a plain overwrite or a lost event.

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] rdata,
  output logic         irq_n
);
  localparam logic [2:0] A_LIVE = 3'd0;
  localparam logic [2:0] A_ON   = 3'd1;
  localparam logic [2:0] A_OFF  = 3'd2;
  localparam logic [2:0] A_MON  = 3'd3;
  localparam logic [2:0] A_MOFF = 3'd4;

  logic [N-1:0] cond_q, on_lat, off_lat, on_msk, off_msk, rd_mux;

  wire [N-1:0] rise   = cond_i & ~cond_q;
  wire [N-1:0] fall   = ~cond_i & cond_q;
  wire [N-1:0] clr_on  = (wr_en && addr == A_ON)  ? wdata : '0;
  wire [N-1:0] clr_off = (wr_en && addr == A_OFF) ? wdata : '0;

  always_comb begin
    case (addr)
      A_LIVE:  rd_mux = cond_i;
      A_ON:    rd_mux = on_lat;
      A_OFF:   rd_mux = off_lat;
      A_MON:   rd_mux = on_msk;
      A_MOFF:  rd_mux = off_msk;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q  <= '0;
      on_lat  <= '0;
      off_lat <= '0;
      on_msk  <= '0;
      off_msk <= '0;
      rdata   <= '0;
    end else begin
      cond_q  <= cond_i;
      on_lat  <= (on_lat & ~clr_on) | rise;
      off_lat <= (off_lat & ~clr_off) | fall;
      if (wr_en && addr == A_MON)  on_msk  <= wdata;
      if (wr_en && addr == A_MOFF) off_msk <= wdata;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign irq_n = ~|((on_lat & on_msk) | (off_lat & off_msk));
endmodule

module alarm_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] cond_i,
  input logic [N-1:0] cond_q,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic [N-1:0] wdata,
  input logic [N-1:0] rdata,
  input logic [N-1:0] on_lat,
  input logic [N-1:0] off_lat,
  input logic [N-1:0] on_msk,
  input logic [N-1:0] off_msk,
  input logic         irq_n
);
  wire [N-1:0] up = cond_i & ~cond_q;
  wire [N-1:0] dn = ~cond_i & cond_q;

  AST_ONSET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((on_lat & $past(up)) == $past(up))); // R4
  AST_ENDING_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((off_lat & $past(dn)) == $past(dn))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (on_lat == ($past(on_lat) | $past(up)))); // R2
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1) |=> ((on_lat & $past(wdata) & ~$past(up)) == '0)); // R6
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_msk == '0 && off_msk == '0) |-> irq_n); // R8
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .cond_q(cond_q),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .on_lat(on_lat), .off_lat(off_lat), .on_msk(on_msk), .off_msk(off_msk),
  .irq_n(irq_n)
);

// File: tb/alarm_irq_ctrl_test.sv
module alarm_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cond_i = '0, wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] rdata;
  logic irq_n;

  int checks = 0, fails = 0;
  logic [7:0] m_on = '0, m_off = '0, m_mon = '0, m_moff = '0, m_prev = '0, m_rd = '0;
  logic [7:0] cur = '0;

  always #2 clk = ~clk;

  alarm_irq_ctrl #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(input logic [2:0] a, input logic [7:0] c);
    case (a)
      3'd0: return c;
      3'd1: return m_on;
      3'd2: return m_off;
      3'd3: return m_mon;
      3'd4: return m_moff;
      default: return 8'h00;
    endcase
  endfunction

  task automatic cyc(input logic [7:0] c, input logic w, input logic r,
                     input logic [2:0] a, input logic [7:0] d);
    logic [7:0] up, dn, c1, c2;
    cond_i = c; wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    if (r) m_rd = sel(a, c);
    up = c & ~m_prev;
    dn = ~c & m_prev;
    c1 = (w && a == 3'd1) ? d : 8'h00;
    c2 = (w && a == 3'd2) ? d : 8'h00;
    m_on  = (m_on & ~c1) | up;
    m_off = (m_off & ~c2) | dn;
    if (w && a == 3'd3) m_mon = d;
    if (w && a == 3'd4) m_moff = d;
    m_prev = c;
    @(negedge clk);
    chk("R8 irq", {7'd0, irq_n}, {7'd0, ~|((m_on & m_mon) | (m_off & m_moff))});
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    cyc(cur, 1'b0, 1'b1, a, 8'h00);
    chk(req, rdata, m_rd);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(cur, 1'b1, 1'b0, a, d);
  endtask

  task automatic idle();
    cyc(cur, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    // R9: reset state
    #9 chk("R9 irq", {7'd0, irq_n}, 8'h01);
    chk("R9 rdata", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 1; a <= 4; a++) rd(3'(a), "R9");

    // R1: exhaustive real-time sweep, R4/R5 latches accumulate
    for (int v = 0; v < 256; v++) begin cur = 8'(v); rd(3'd0, "R1"); end
    rd(3'd1, "R4"); rd(3'd2, "R5");
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd1, "R6"); rd(3'd2, "R6");

    // R4/R5: single-bit walks
    for (int b = 0; b < 8; b++) begin
      cur = 8'h00; idle(); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
      cur = 8'(1 << b); idle(); rd(3'd1, "R4");
      cur = 8'h00; idle(); rd(3'd2, "R5");
    end

    // R6: clear while condition persists, no re-set
    cur = 8'hFF; idle(); wr(3'd2, 8'hFF);
    wr(3'd1, 8'h0F); rd(3'd1, "R6");
    idle(); idle(); rd(3'd1, "R6");
    wr(3'd1, 8'hF0); rd(3'd1, "R6");

    // R7: clear collides with a new edge
    cur = 8'h7F; idle(); wr(3'd2, 8'hFF);
    cur = 8'hFF; wr(3'd1, 8'h80); rd(3'd1, "R7");
    cur = 8'h7F; wr(3'd2, 8'h80); rd(3'd2, "R7");

    // R2: repeated reads leave latches alone
    for (int k = 0; k < 6; k++) rd(3'(k % 3), "R2");
    rd(3'd1, "R2"); rd(3'd2, "R2");

    // R3: rdata holds while inputs move without a read
    cur = 8'h3C; rd(3'd0, "R3");
    for (int k = 0; k < 5; k++) begin
      cur = 8'(k * 37); idle(); chk("R3", rdata, m_rd);
    end

    // R8: mask sweep over fixed latch pattern
    cur = 8'h00; idle(); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    cur = 8'hA5; idle(); cur = 8'h00; idle();
    wr(3'd1, 8'hFF);
    cur = 8'hA5; idle();
    for (int m = 0; m < 256; m++) begin wr(3'd3, 8'(m)); if (m % 32 == 0) rd(3'd3, "R8"); end
    wr(3'd3, 8'h00);
    for (int m = 0; m < 256; m += 17) begin wr(3'd4, 8'(m)); rd(3'd4, "R8"); end
    wr(3'd2, 8'hFF); rd(3'd2, "R8");

    // R10: writes to read-only and unmapped addresses
    wr(3'd0, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    for (int a = 1; a <= 7; a++) rd(3'(a), "R10");

    finish_up();
  end
endmodule